// File: doc/BRIEF.md
# Scaled Modulation Routing Mixer

This block builds the control value for each of twelve analog destinations in a synthesizer voice. One update is a set of ten modulation samples: eight envelope levels, one LFO value and one noise value. For every destination the block scales each sample by a signed factor held for that destination, sums the products, adds a static base level, and limits the result to the unsigned output range. One multiply-accumulate unit serves all twelve destinations in turn, so a full update takes one acceptance cycle plus eleven cycles per destination.

The ten samples arrive on a valid/ready input. The input is ready only while the block is idle. While it computes, the input is held off and nothing new is taken. Results leave on a valid/ready output tagged with the destination number. A result stays on the output, unchanged, until the consumer takes it. Only then does the block move to the next destination.

Scale factors and base levels are loaded through a plain write port into a staging table. The whole staging table is copied into the working table at the moment an update is accepted. A write therefore never changes an update that is already in progress.

Top module: `mod_route_mixer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. All scale factors and base levels are zero, so an update with no prior writes yields 0 on every destination.
- R2: Each destination's result is base + floor(sum over slots of sample × factor / 128). Samples are unsigned `SRC_W`-bit values. Slot s is read from `in_src[s*SRC_W +: SRC_W]`, with slots 0–7 for the envelopes, 8 for the LFO and 9 for the noise.
- R3: A scale factor is an 8-bit two's-complement value taken from `cfg_data[7:0]`, meaning factor/128. Negative factors subtract from the sum.
- R4: A sum above 4095 is output as 4095 and does not wrap.
- R5: A sum below 0 is output as 0 and does not wrap.
- R6: Every accepted update yields exactly twelve results, with `out_dest` running 0, 1, … 11 in that order.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_dest` and `out_data` hold their values.
- R8: `in_ready` is 0 from the cycle after acceptance until the last result is taken. Samples offered in that time are not taken and do not affect the results.
- R9: A configuration write lands in the staging table. It affects only updates accepted after the write, never the update in progress.
- R10: Writes use these codes. `cfg_slot` 0–9 selects that slot's scale factor and `cfg_slot` 10 selects the base level. A `cfg_slot` above 10, or a `cfg_dest` above 11, is ignored.
- R11: The base level is the full 12-bit unsigned `cfg_data`, from 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Block idle and able to take a sample set |
| in_src | input | N_SRC*SRC_W (120) | Ten packed unsigned samples, slot 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dest | input | DEST_IW (4) | Destination being written |
| cfg_slot | input | SLOT_IW (4) | Slot 0–9 for a scale factor, 10 for the base level |
| cfg_data | input | OUT_W (12) | Write value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | DEST_IW (4) | Destination of the current result |
| out_data | output | OUT_W (12) | Clamped result |

## Verification
The bench uses the default parameters: twelve destinations, ten 12-bit sources, 8-bit factors and a 24-bit accumulator. With these values the full-scale extremes are reachable. Ten sources at 4095 with factor +127 on a base of 4000 drive the sum far past the top limit, and factor −128 drives it far below zero. The 4-bit destination and slot fields can carry the unused codes 12–15 and 11–15, so the ignore rule is exercised directly at the port. One destination is held under back-pressure in the middle of an update. A write and a refused sample set are also placed in the middle of an update.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } mrm_state_e;
endpackage

// File: rtl/mrm_coef_bank.sv
module mrm_coef_bank #(
  parameter int N_DEST  = 12,
  parameter int N_SRC   = 10,
  parameter int COEF_W  = 8,
  parameter int OUT_W   = 12,
  parameter int DEST_IW = 4,
  parameter int SLOT_IW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DEST_IW-1:0]       wr_dest,
  input  logic [SLOT_IW-1:0]       wr_slot,
  input  logic [OUT_W-1:0]         wr_data,
  input  logic                     load,
  input  logic [DEST_IW-1:0]       rd_dest,
  input  logic [SLOT_IW-1:0]       rd_slot,
  output logic signed [COEF_W-1:0] rd_coef,
  output logic [OUT_W-1:0]         rd_off
);
  localparam logic [DEST_IW-1:0] DEST_LIM = DEST_IW'(N_DEST);
  localparam logic [SLOT_IW-1:0] OFF_SLOT = SLOT_IW'(N_SRC);

  logic [N_DEST-1:0][N_SRC-1:0][COEF_W-1:0] coef_sh, coef_act;
  logic [N_DEST-1:0][OUT_W-1:0]             off_sh, off_act;
  logic dest_ok;

  assign dest_ok = (wr_dest < DEST_LIM);

  // staging table: written at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_sh <= '0;
      off_sh  <= '0;
    end else if (wr_en && dest_ok) begin
      if (wr_slot < OFF_SLOT)
        coef_sh[wr_dest][wr_slot] <= wr_data[COEF_W-1:0];
      else if (wr_slot == OFF_SLOT)
        off_sh[wr_dest] <= wr_data;
    end
  end

  // working table: copied only when an update is accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_act <= '0;
      off_act  <= '0;
    end else if (load) begin
      coef_act <= coef_sh;
      off_act  <= off_sh;
    end
  end

  assign rd_coef = $signed(coef_act[rd_dest][rd_slot]);
  assign rd_off  = off_act[rd_dest];

  // working table frozen between acceptances
  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(coef_act) && $stable(off_act)));

  // out-of-range destination writes leave the staging table alone
  p_bad_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dest_ok) |=> ($stable(coef_sh) && $stable(off_sh)));

  // unused slot codes leave the staging table alone
  p_bad_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_slot > OFF_SLOT)) |=> ($stable(coef_sh) && $stable(off_sh)));
endmodule

// File: rtl/mrm_mac.sv
module mrm_mac #(
  parameter int SRC_W  = 12,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 12,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     first,
  input  logic [SRC_W-1:0]         src,
  input  logic signed [COEF_W-1:0] coef,
  input  logic [OUT_W-1:0]         off,
  output logic [OUT_W-1:0]         result
);
  localparam int FRAC   = COEF_W - 1;
  localparam int PROD_W = SRC_W + 1 + COEF_W;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << OUT_W) - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  base, acc_q, acc_d, scaled;

  assign prod  = $signed({1'b0, src}) * coef;
  assign base  = $signed(ACC_W'(off)) <<< FRAC;
  assign acc_d = (first ? base : acc_q) + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign scaled = acc_q >>> FRAC;

  always_comb begin
    if (scaled < 0)             result = '0;
    else if (scaled > OUT_MAX)  result = '1;
    else                        result = scaled[OUT_W-1:0];
  end

  // accumulator only moves on enabled cycles
  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/mrm_seq.sv
module mrm_seq
  import mrm_pkg::*;
#(
  parameter int N_DEST  = 12,
  parameter int N_SRC   = 10,
  parameter int DEST_IW = 4,
  parameter int SLOT_IW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               load,
  output logic               mac_en,
  output logic               mac_first,
  output logic [DEST_IW-1:0] dest,
  output logic [SLOT_IW-1:0] slot
);
  localparam logic [DEST_IW-1:0] LAST_DEST = DEST_IW'(N_DEST - 1);
  localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(N_SRC - 1);

  mrm_state_e state_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign load      = in_ready && in_valid;
  assign mac_en    = (state_q == ST_MAC);
  assign mac_first = mac_en && (slot == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dest    <= '0;
      slot    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_MAC;
          dest    <= '0;
          slot    <= '0;
        end
        ST_MAC: begin
          if (slot == LAST_SLOT) state_q <= ST_OUT;
          else                   slot    <= slot + 1'b1;
        end
        ST_OUT: if (out_ready) begin
          if (dest == LAST_DEST) begin
            state_q <= ST_IDLE;
          end else begin
            dest    <= dest + 1'b1;
            slot    <= '0;
            state_q <= ST_MAC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dest)));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_start_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && dest == '0));

  p_dest_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dest <= LAST_DEST));

  p_not_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && dest != LAST_DEST) |=> !in_ready);
endmodule

// File: rtl/mod_route_mixer.sv
module mod_route_mixer #(
  parameter int N_DEST  = 12,
  parameter int N_SRC   = 10,
  parameter int SRC_W   = 12,
  parameter int COEF_W  = 8,
  parameter int OUT_W   = 12,
  parameter int ACC_W   = 24,
  parameter int DEST_IW = $clog2(N_DEST + 1),
  parameter int SLOT_IW = $clog2(N_SRC + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N_SRC*SRC_W-1:0] in_src,
  input  logic                   cfg_we,
  input  logic [DEST_IW-1:0]     cfg_dest,
  input  logic [SLOT_IW-1:0]     cfg_slot,
  input  logic [OUT_W-1:0]       cfg_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DEST_IW-1:0]     out_dest,
  output logic [OUT_W-1:0]       out_data
);
  logic [N_SRC-1:0][SRC_W-1:0] src_q;
  logic                        load, mac_en, mac_first;
  logic [DEST_IW-1:0]          dest;
  logic [SLOT_IW-1:0]          slot;
  logic signed [COEF_W-1:0]    coef;
  logic [OUT_W-1:0]            off;

  always_ff @(posedge clk) begin
    if (!rst_n)    src_q <= '0;
    else if (load) src_q <= in_src;
  end

  mrm_seq #(
    .N_DEST(N_DEST), .N_SRC(N_SRC), .DEST_IW(DEST_IW), .SLOT_IW(SLOT_IW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .load(load),
    .mac_en(mac_en), .mac_first(mac_first), .dest(dest), .slot(slot)
  );

  mrm_coef_bank #(
    .N_DEST(N_DEST), .N_SRC(N_SRC), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .DEST_IW(DEST_IW), .SLOT_IW(SLOT_IW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_dest(cfg_dest),
    .wr_slot(cfg_slot), .wr_data(cfg_data), .load(load),
    .rd_dest(dest), .rd_slot(slot), .rd_coef(coef), .rd_off(off)
  );

  mrm_mac #(
    .SRC_W(SRC_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .ACC_W(ACC_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
    .src(src_q[slot]), .coef(coef), .off(off), .result(out_data)
  );

  assign out_dest = dest;

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  p_src_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(src_q));
endmodule

// File: tb/mod_route_mixer_bench.sv
module mod_route_mixer_bench;
  localparam int ND = 12, NS = 10, SW = 12, OW = 12;
  typedef logic [NS*SW-1:0] vec_t;

  localparam vec_t VECS [5] = '{
    {NS{12'h000}},
    {NS{12'hFFF}},
    {12'd3600, 12'd3200, 12'd2800, 12'd2400, 12'd2000,
     12'd1600, 12'd1200, 12'd800,  12'd400,  12'd0},
    {5{12'hFFF, 12'h000}},
    {12'h123, 12'h9AB, 12'h456, 12'hCDE, 12'h789,
     12'h0F0, 12'hE01, 12'h35A, 12'hB7C, 12'h64D}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  vec_t in_src = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_dest = '0, cfg_slot = '0;
  logic [OW-1:0] cfg_data = '0;
  logic out_valid, out_ready = 1;
  logic [3:0] out_dest;
  logic [OW-1:0] out_data;

  int checks = 0, errors = 0, cyc = 0;
  int sh_coef [ND][NS], sh_off [ND];
  int ac_coef [ND][NS], ac_off [ND];
  int got [ND];

  always #4 clk = ~clk;

  mod_route_mixer u_mod_route_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .cfg_we(cfg_we), .cfg_dest(cfg_dest),
    .cfg_slot(cfg_slot), .cfg_data(cfg_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int d, input vec_t v);
    int acc = ac_off[d] * 128;
    for (int s = 0; s < NS; s++) acc += int'(v[s*SW +: SW]) * ac_coef[d][s];
    acc = acc >>> 7;
    if (acc < 0) acc = 0;
    if (acc > 4095) acc = 4095;
    return acc;
  endfunction

  task automatic cfg_write(input int d, input int s, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_dest = 4'(d); cfg_slot = 4'(s); cfg_data = OW'(val);
    if (d < ND && s < NS) sh_coef[d][s] = val;
    else if (d < ND && s == NS) sh_off[d] = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic start_tick(input vec_t v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_src = v; in_valid = 1;
    ac_coef = sh_coef; ac_off = sh_off;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic collect(input vec_t v, input bit stall, input string req);
    for (int k = 0; k < ND; k++) begin
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      chk(out_dest == 4'(k), "R6", int'(out_dest), k);
      got[k] = int'(out_data);
      chk(got[k] == model(k, v), req, got[k], model(k, v));
      if (stall && k == 3) begin
        out_ready = 0;
        for (int w = 0; w < 4; w++) begin
          @(negedge clk);
          chk(out_valid && out_dest == 4'(k) && int'(out_data) == got[k],
              "R7", int'(out_data), got[k]);
        end
        out_ready = 1;
      end
    end
    @(negedge clk);
    chk(in_ready == 1, "R8 idle after last", int'(in_ready), 1);
  endtask

  initial begin
    for (int d = 0; d < ND; d++) begin
      sh_off[d] = 0;
      for (int s = 0; s < NS; s++) sh_coef[d][s] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1, "R1", int'(in_ready), 1);
    chk(out_valid == 0, "R1", int'(out_valid), 0);
    rst_n = 1;
    start_tick(VECS[1]);
    collect(VECS[1], 0, "R1");

    // configure: signed factors (R3) and full-range base levels (R11)
    for (int d = 0; d < ND - 2; d++) begin
      for (int s = 0; s < NS; s++)
        cfg_write(d, s, ((d * 37 + s * 11 + 5) % 256) - 128);
      cfg_write(d, NS, (d * 350) % 4096);
    end
    for (int s = 0; s < NS; s++) cfg_write(10, s, 127);
    cfg_write(10, NS, 4000);
    for (int s = 0; s < NS; s++) cfg_write(11, s, -128);
    cfg_write(11, NS, 100);

    // vector table walk: R2 and R3
    for (int i = 0; i < 5; i++) begin
      start_tick(VECS[i]);
      collect(VECS[i], 0, "R2 R3");
    end

    // R11: base level shows through with zero samples
    start_tick(VECS[0]);
    collect(VECS[0], 0, "R11");
    chk(got[10] == 4000, "R11", got[10], 4000);

    // R4 / R5 saturation at both ends
    start_tick(VECS[1]);
    collect(VECS[1], 0, "R4 R5");
    chk(got[10] == 4095, "R4", got[10], 4095);
    chk(got[11] == 0, "R5", got[11], 0);

    // R7 back-pressure on destination 3
    start_tick(VECS[4]);
    collect(VECS[4], 1, "R7");

    // R8 offered samples refused while busy; R9 mid-update write deferred
    start_tick(VECS[2]);
    in_src = VECS[1]; in_valid = 1;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      chk(in_ready == 0, "R8", int'(in_ready), 0);
    end
    in_valid = 0;
    cfg_write(0, NS, 4095);
    collect(VECS[2], 0, "R8 R9");
    start_tick(VECS[0]);
    collect(VECS[0], 0, "R9");
    chk(got[0] == 4095, "R9", got[0], 4095);

    // R10 unused destination and slot codes ignored
    cfg_write(12, 0, 77);
    cfg_write(15, NS, 99);
    cfg_write(1, 11, 55);
    cfg_write(2, 15, 66);
    start_tick(VECS[3]);
    collect(VECS[3], 0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule